// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

The block predicts whether a conditional branch will be taken. It runs two direction predictors side by side:

- An address-indexed table of 2-bit counters, called the local table here.
- A history-hashed table of 2-bit counters, called the hashed table. Its index is the branch address bits XORed with a global register that holds recent branch outcomes.

A third table of 2-bit chooser counters is indexed by the branch address. For each branch it decides which of the two component predictions is sent out. This lets each branch settle on whichever scheme has recently served it better.

The fetch side presents a PC on the lookup port. It receives the final prediction combinationally, together with both component predictions for debug. When a branch resolves, the back end presents its PC and its real outcome on the training port for one clock cycle. On that clock edge all three tables and the history register are updated.

There is no target prediction and no speculative history repair. The history moves only on resolved outcomes.

Top module: `tourney_pred`

## Requirements
- R1: After reset every counter in all three tables holds 2 and the global history holds zero. Any lookup PC therefore gives `pred_bim`=1, `pred_gsh`=1 and `pred_taken`=1.
- R2: The local table has 2^BIM_IDX_W entries (64 by default), indexed by `pc[PC_LSB +: BIM_IDX_W]` (PC_LSB=2).
  - Each entry is a saturating 2-bit counter. A resolved taken outcome increments it, capped at 3. A not-taken outcome decrements it, floored at 0.
  - `pred_bim` is 1 exactly when the counter is 2 or 3.
- R3: The hashed table has twice as many entries as the local table (128 by default). It is indexed by `history ^ pc[PC_LSB +: BIM_IDX_W+1]`, and its counters train and predict under the same rules as R2.
- R4: The global history is BIM_IDX_W+1 bits wide. A training event shifts it left by one and puts the resolved outcome into bit 0 (1 = taken). The hashed-table update of that same event uses the value before the shift. Without a training event the history holds.
- R5: The chooser table has the same number of entries and the same index as the local table. A chooser value of 2 or 3 makes `pred_taken` equal `pred_bim`; a value of 0 or 1 makes it equal `pred_gsh`.
- R6: On a training event the chooser entry changes only if exactly one component prediction for that PC was correct. It increments (saturating at 3) when the local prediction was the correct one, and decrements (saturating at 0) when the hashed prediction was the correct one. Component correctness is judged from the table contents before that edge.
- R7: Lookup outputs are combinational from the stored state. A training event in the same cycle affects lookups only from the following cycle on.
- R8: Entries carry no tag. PCs whose index bits match share counters, so training one PC changes the prediction of an alias that differs only above the index bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W (32) | Lookup branch address |
| pred_taken | output | 1 | Final predicted direction (1 = taken) |
| pred_bim | output | 1 | Local-table prediction (debug) |
| pred_gsh | output | 1 | Hashed-table prediction (debug) |
| upd_valid | input | 1 | Training event strobe, one per resolved branch |
| upd_pc | input | PC_W (32) | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The bench drives three kinds of stimulus:

- Saturation runs on a single PC. A counter that wrapped instead of clamping would flip its prediction after one extra taken or not-taken outcome.
- Same-cycle lookup and training of one PC. A design that bypassed the new value would show the trained result one cycle early.
- Aliased PCs. A design that tagged entries, or indexed with the wrong bits, would leave the alias prediction unchanged.

A cycle-accurate model in the bench follows long random branch streams with biased and pattern outcomes. This catches a history that shifts before the hashed update uses it, a missing XOR, and a chooser trained when both components agree. Each of these faults makes the chosen prediction drift away from the model within a few dozen branches.

// File: rtl/tourney_pred_pkg.sv
package tourney_pred_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'd2;

    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
        ctr2_t nxt;
        if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
        else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr2_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/tourney_ctr_table.sv
module tourney_ctr_table
    import tourney_pred_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_cnt,
    input  logic [IDX_W-1:0] trn_idx,
    output ctr2_t            trn_cnt,
    input  logic             trn_en,
    input  logic             trn_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t cells [DEPTH];

    assign rd_cnt  = cells[rd_idx];
    assign trn_cnt = cells[trn_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) cells[e] <= CTR_INIT;
        end else if (trn_en) begin
            cells[trn_idx] <= ctr_step(cells[trn_idx], trn_up);
        end
    end
endmodule

// File: rtl/tourney_hist_reg.sv
module tourney_hist_reg #(
    parameter int HIST_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
    end
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
    import tourney_pred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int BIM_IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_bim,
    output logic            pred_gsh,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int GSH_IDX_W = BIM_IDX_W + 1;
    localparam int HIST_W    = GSH_IDX_W;

    logic [HIST_W-1:0]    hist_q;
    logic [BIM_IDX_W-1:0] lk_bim_idx, tr_bim_idx;
    logic [GSH_IDX_W-1:0] lk_gsh_idx, tr_gsh_idx;
    ctr2_t lk_bim_cnt, lk_gsh_cnt, lk_sel_cnt;
    ctr2_t tr_bim_cnt, tr_gsh_cnt, tr_sel_cnt;
    logic  tr_bim_ok, tr_gsh_ok, tr_sel_en;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_LSB+GSH_IDX_W], pred_pc[PC_LSB-1:0],
                              upd_pc[PC_W-1:PC_LSB+GSH_IDX_W],  upd_pc[PC_LSB-1:0],
                              tr_sel_cnt};

    assign lk_bim_idx = pred_pc[PC_LSB +: BIM_IDX_W];
    assign tr_bim_idx = upd_pc[PC_LSB +: BIM_IDX_W];
    assign lk_gsh_idx = pred_pc[PC_LSB +: GSH_IDX_W] ^ hist_q;
    assign tr_gsh_idx = upd_pc[PC_LSB +: GSH_IDX_W] ^ hist_q;

    tourney_hist_reg #(.HIST_W(HIST_W)) hist_i (
        .clk(clk), .rst_n(rst_n),
        .shift_en(upd_valid), .shift_bit(upd_taken),
        .hist(hist_q)
    );

    tourney_ctr_table #(.IDX_W(BIM_IDX_W)) bim_tbl_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_bim_idx), .rd_cnt(lk_bim_cnt),
        .trn_idx(tr_bim_idx), .trn_cnt(tr_bim_cnt),
        .trn_en(upd_valid), .trn_up(upd_taken)
    );

    tourney_ctr_table #(.IDX_W(GSH_IDX_W)) gsh_tbl_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_gsh_idx), .rd_cnt(lk_gsh_cnt),
        .trn_idx(tr_gsh_idx), .trn_cnt(tr_gsh_cnt),
        .trn_en(upd_valid), .trn_up(upd_taken)
    );

    assign tr_bim_ok = (ctr_says_taken(tr_bim_cnt) == upd_taken);
    assign tr_gsh_ok = (ctr_says_taken(tr_gsh_cnt) == upd_taken);
    assign tr_sel_en = upd_valid && (tr_bim_ok != tr_gsh_ok);

    tourney_ctr_table #(.IDX_W(BIM_IDX_W)) sel_tbl_i (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_bim_idx), .rd_cnt(lk_sel_cnt),
        .trn_idx(tr_bim_idx), .trn_cnt(tr_sel_cnt),
        .trn_en(tr_sel_en), .trn_up(tr_bim_ok)
    );

    always_comb begin
        pred_bim   = ctr_says_taken(lk_bim_cnt);
        pred_gsh   = ctr_says_taken(lk_gsh_cnt);
        pred_taken = ctr_says_taken(lk_sel_cnt) ? pred_bim : pred_gsh;
    end
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_taken,
    input logic              pred_bim,
    input logic              pred_gsh,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist_q
);
    AST_RESET_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pred_taken && pred_bim && pred_gsh)); // R1

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)}); // R4

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q)); // R4

    AST_FINAL_IS_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken == pred_bim) || (pred_taken == pred_gsh)); // R5

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!upd_valid) && $stable(pred_pc)) |->
            ($stable(pred_taken) && $stable(pred_bim) && $stable(pred_gsh))); // R7
endmodule

bind tourney_pred tourney_pred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .hist_q(hist_q)
);

// File: tb/tourney_pred_tb_top.sv
`timescale 1ns/1ps
module tourney_pred_tb_top;
    localparam int PC_W = 32;
    localparam int LSB  = 2;
    localparam int BW   = 6;
    localparam int GW   = BW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
    logic upd_valid = 1'b0, upd_taken = 1'b0;
    logic pred_taken, pred_bim, pred_gsh;

    always #2.5 clk = ~clk;

    tourney_pred dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    int m_bim [1<<BW];
    int m_gsh [1<<GW];
    int m_sel [1<<BW];
    logic [GW-1:0] m_hist;

    logic [2:0] exp_q [$];
    string      tag_q [$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    function automatic int sat(input int v, input bit up);
        if (up) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1<<BW); i++) begin m_bim[i] = 2; m_sel[i] = 2; end
        for (int i = 0; i < (1<<GW); i++) m_gsh[i] = 2;
        m_hist = '0;
    endtask

    task automatic step(input logic [PC_W-1:0] ppc, input bit uv,
                        input logic [PC_W-1:0] upc, input bit ut, input string tag);
        logic [BW-1:0] bi, ubi;
        logic [GW-1:0] gi, ugi;
        bit b, g, f, bo, go;
        @(negedge clk);
        pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        bi = ppc[LSB +: BW];
        gi = ppc[LSB +: GW] ^ m_hist;
        b = (m_bim[bi] >= 2);
        g = (m_gsh[gi] >= 2);
        f = (m_sel[bi] >= 2) ? b : g;
        exp_q.push_back({f, b, g});
        tag_q.push_back(tag);
        @(posedge clk);
        if (uv) begin
            ubi = upc[LSB +: BW];
            ugi = upc[LSB +: GW] ^ m_hist;
            bo = ((m_bim[ubi] >= 2) == ut);
            go = ((m_gsh[ugi] >= 2) == ut);
            if (bo != go) m_sel[ubi] = sat(m_sel[ubi], bo);
            m_bim[ubi] = sat(m_bim[ubi], ut);
            m_gsh[ugi] = sat(m_gsh[ugi], ut);
            m_hist = {m_hist[GW-2:0], ut};
        end
    endtask

    // monitor: pops one expected item per cycle, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({pred_taken, pred_bim, pred_gsh} !== e) begin
                n_bad++;
                $display("FAIL %s: {final,local,hashed} actual=%b expected=%b",
                         t, {pred_taken, pred_bim, pred_gsh}, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pcs [8];
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state seen on several PCs
        for (int k = 0; k < 6; k++) step(32'h1000 + 32'(k*52), 0, 0, 0, "R1");
        // R2: saturate up then down on one PC, looking at it every cycle
        for (int k = 0; k < 4; k++) step(32'h40, 1, 32'h40, 1, "R2");
        for (int k = 0; k < 6; k++) step(32'h40, 1, 32'h40, 0, "R2");
        for (int k = 0; k < 3; k++) step(32'h40, 1, 32'h40, 1, "R2");
        step(32'h40, 0, 0, 0, "R2");
        // R7: same-cycle training must not alter the current lookup
        step(32'h84, 1, 32'h84, 0, "R7");
        step(32'h84, 1, 32'h84, 0, "R7");
        step(32'h84, 0, 0, 0, "R7");
        // R8: alias above the index bits shares entries
        for (int k = 0; k < 4; k++) step(32'h0C, 1, 32'h0C + 32'h200, 0, "R8");
        step(32'h0C, 0, 0, 0, "R8");
        step(32'h0C + 32'h100, 0, 0, 0, "R8");
        // R3 R4 R5 R6: random streams against the model
        for (int k = 0; k < 8; k++) pcs[k] = 32'($urandom_range(0, 1023)) << LSB;
        for (int n = 0; n < 4000; n++) begin
            int  s;
            bit  t;
            string tg;
            s = $urandom_range(0, 7);
            case (s % 4)
                0: t = ($urandom_range(0, 9) != 0);
                1: t = ($urandom_range(0, 9) == 0);
                2: t = (n % 3 != 0);
                default: t = m_hist[1];
            endcase
            case (n % 4)
                0: tg = "R3";
                1: tg = "R4";
                2: tg = "R5";
                default: tg = "R6";
            endcase
            step(pcs[$urandom_range(0, 7)], ($urandom_range(0, 4) != 0), pcs[s], t, tg);
        end
        step(32'h0, 0, 0, 0, "R5");
        @(negedge clk); #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule